// File: doc/BRIEF.md
# Card Clock Generator

This block derives the clock sent to a memory card from the master clock. A 16-bit control word sets an 8-bit divide value, a run enable, a divider bypass, an idle power-save mode, a data-bus width and a flow-control enable. A variant input selects one of two divide laws. The same input also selects which bit of the control word holds the flow-control enable.

The divider produces a registered card clock and a one-cycle strobe in the master-clock cycle where each card-clock high phase begins. The data path uses two status inputs to stop the card clock. One reports that its FIFO cannot accept or supply data. The other reports that the bus is idle. Neither stop cuts a period short: the clock always finishes its current period, then rests low. A new divide value takes effect only at a period boundary. The block also holds the selected bus width in a register for the data-path logic.

Control word fields: divide value in bits 7:0, enable bit 8, power-save bit 9, bypass bit 10, 4-bit bus bit 11, 8-bit bus bit 12. The flow-control enable is bit 13 under the standard law and bit 14 under the alternate law.

Top module: `mmc_cclk_gen`

## Requirements
- R1: With `alt_law`=0, the card-clock period is 2(N+1) master cycles and its high phase is N+1 cycles, where N is the divide field. This holds for every N from 0 to 255.
- R2: With `alt_law`=1, the period is N+2 master cycles and its high phase is floor((N+2)/2) cycles.
- R3: With `alt_law`=1 and N=0, the card clock is high for one master cycle and low for one, repeating.
- R4: When bypass (bit 10) and enable are both set, `card_edge` is 1 in every master cycle, `card_clk` follows the master clock, and the divide field has no effect.
- R5: While enable (bit 8) is clear, `card_clk` is 0 and `card_edge` is 0. This starts from the first cycle after the clear, even if it arrives in mid-period.
- R6: When the flow-control enable is set and `fifo_ready` is 0, no new period starts and `card_clk` rests low once the current period ends. The flow-control enable is bit 13 when `alt_law`=0 and bit 14 when `alt_law`=1. The bit at the other position is ignored. Once `fifo_ready` returns to 1, a new period starts on the next master edge.
- R7: When power-save (bit 9) is set and `bus_idle` is 1, no new period starts and `card_clk` rests low.
- R8: A divide value written in mid-period does not change the period in progress. The next period uses the new value.
- R9: `card_edge` is one master cycle wide in divider mode. It is 1 exactly in the first cycle of each high phase of `card_clk`.
- R10: `bus_width` is 2 when bit 12 is set (this wins over bit 11), 1 when only bit 11 is set, and 0 otherwise. It updates one master cycle after the control word changes.
- R11: During reset, `card_clk`, `card_edge` and `bus_width` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 16 | Clock control word |
| alt_law | input | 1 | Divide-law variant select (0: 2(N+1), 1: N+2) |
| fifo_ready | input | 1 | Data FIFO can accept or supply data |
| bus_idle | input | 1 | Card bus has no transfer in progress |
| card_clk | output | 1 | Card clock |
| card_edge | output | 1 | Strobe in the first cycle of each card-clock high phase |
| bus_width | output | 2 | Selected bus width: 0 = 1 bit, 1 = 4 bits, 2 = 8 bits |

## Verification
Inputs change on the falling master edge and outputs are sampled on the falling edge. A control word that enables the divider therefore raises `card_edge` and `card_clk` at the first sample after it. `bus_width` also changes at that first sample. A cleared enable drops `card_clk` at the first sample as well.

A released stall shows a fresh edge one sample after `fifo_ready` or `bus_idle` changes. A stall applied in mid-period shows nothing until the period in progress has drained.

Period and high-phase lengths are measured edge to edge by a monitor that counts samples. Directed checks wait for a sampled `card_edge` before they change the control word. Each check is then judged at a fixed sample offset from that edge.

// File: rtl/mmc_cclk_pkg.sv
package mmc_cclk_pkg;

    parameter int DIV_W = 8;
    parameter int PER_W = DIV_W + 2;

    // control word bit positions
    parameter int POS_EN    = DIV_W;
    parameter int POS_PSAVE = DIV_W + 1;
    parameter int POS_BYP   = DIV_W + 2;
    parameter int POS_BUS4  = DIV_W + 3;
    parameter int POS_BUS8  = DIV_W + 4;

    typedef enum logic [1:0] {
        BUS_X1 = 2'd0,
        BUS_X4 = 2'd1,
        BUS_X8 = 2'd2
    } bus_width_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             enable;
        logic             psave;
        logic             bypass;
        logic             flow;
        bus_width_e       width;
    } cclk_cfg_t;

    // card-clock period in master cycles for a divide value and law
    function automatic logic [PER_W-1:0] period_of(input logic [DIV_W-1:0] d,
                                                   input logic alt);
        logic [PER_W-1:0] dz;
        dz = PER_W'(d);
        if (alt)
            return dz + PER_W'(2);
        return (dz + PER_W'(1)) << 1;
    endfunction

    // low phase length: the high phase takes the floor half
    function automatic logic [PER_W-1:0] low_of(input logic [PER_W-1:0] per);
        return per - (per >> 1);
    endfunction

endpackage

// File: rtl/mmc_cclk_decode.sv
module mmc_cclk_decode
    import mmc_cclk_pkg::*;
#(
    parameter int CTRL_W     = 16,
    parameter int FC_BIT_STD = 13,
    parameter int FC_BIT_ALT = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              alt_law,
    output cclk_cfg_t         cfg,
    output bus_width_e        width_q
);

    always_comb begin
        cfg.div    = ctrl_word[DIV_W-1:0];
        cfg.enable = ctrl_word[POS_EN];
        cfg.psave  = ctrl_word[POS_PSAVE];
        cfg.bypass = ctrl_word[POS_BYP];
        cfg.flow   = alt_law ? ctrl_word[FC_BIT_ALT] : ctrl_word[FC_BIT_STD];
        if (ctrl_word[POS_BUS8])
            cfg.width = BUS_X8;
        else if (ctrl_word[POS_BUS4])
            cfg.width = BUS_X4;
        else
            cfg.width = BUS_X1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            width_q <= BUS_X1;
        else
            width_q <= cfg.width;
    end

    assert_wide8_wins_R10: assert property (@(posedge clk) disable iff (rst)
        ctrl_word[POS_BUS8] |=> width_q == BUS_X8);

    assert_wide4_only_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_word[POS_BUS4] && !ctrl_word[POS_BUS8]) |=> width_q == BUS_X4);

endmodule

// File: rtl/mmc_cclk_gate.sv
module mmc_cclk_gate
    import mmc_cclk_pkg::*;
(
    input  cclk_cfg_t cfg,
    input  logic      fifo_ready,
    input  logic      bus_idle,
    output logic      hold
);

    logic flow_stall;
    logic idle_stall;

    always_comb begin
        flow_stall = cfg.flow && !fifo_ready;
        idle_stall = cfg.psave && bus_idle;
        hold       = flow_stall || idle_stall;
    end

endmodule

// File: rtl/mmc_cclk_core.sv
module mmc_cclk_core
    import mmc_cclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cclk_cfg_t cfg,
    input  logic      alt_law,
    input  logic      hold,
    output logic      card_clk,
    output logic      card_edge
);

    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] lo_q;
    logic [PER_W-1:0] per_new;
    logic [PER_W-1:0] cnt_dec;
    logic             clk_q;
    logic             div_edge_q;
    logic             byp_q;
    logic             run_div;

    always_comb begin
        per_new = period_of(cfg.div, alt_law);
        cnt_dec = cnt_q - PER_W'(1);
        run_div = cfg.enable && !cfg.bypass;
    end

    // divider: cnt_q holds the master cycles left in the current period
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            lo_q       <= '0;
            clk_q      <= 1'b0;
            div_edge_q <= 1'b0;
        end else if (!run_div) begin
            cnt_q      <= '0;
            clk_q      <= 1'b0;
            div_edge_q <= 1'b0;
        end else if (cnt_q == '0) begin
            if (hold) begin
                clk_q      <= 1'b0;
                div_edge_q <= 1'b0;
            end else begin
                cnt_q      <= per_new - PER_W'(1);
                lo_q       <= low_of(per_new);
                clk_q      <= 1'b1;
                div_edge_q <= 1'b1;
            end
        end else begin
            cnt_q      <= cnt_dec;
            clk_q      <= (cnt_dec >= lo_q);
            div_edge_q <= 1'b0;
        end
    end

    // bypass path: master clock passed through while running
    always_ff @(posedge clk) begin
        if (rst)
            byp_q <= 1'b0;
        else
            byp_q <= cfg.enable && cfg.bypass && !hold;
    end

    assign card_clk  = byp_q ? clk : clk_q;
    assign card_edge = div_edge_q || byp_q;

    assert_edge_in_high_R9: assert property (@(posedge clk) disable iff (rst)
        div_edge_q |-> clk_q);

    assert_edge_single_R9: assert property (@(posedge clk) disable iff (rst)
        div_edge_q |=> !div_edge_q);

    assert_off_when_disabled_R5: assert property (@(posedge clk) disable iff (rst)
        !cfg.enable |=> (!clk_q && !div_edge_q && !byp_q));

    assert_period_len_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |=> $stable(lo_q));

    assert_hold_blocks_start_R6: assert property (@(posedge clk) disable iff (rst)
        (hold && cnt_q == '0) |=> !div_edge_q);

endmodule

// File: rtl/mmc_cclk_gen.sv
module mmc_cclk_gen
    import mmc_cclk_pkg::*;
#(
    parameter int CTRL_W     = 16,
    parameter int FC_BIT_STD = 13,
    parameter int FC_BIT_ALT = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              alt_law,
    input  logic              fifo_ready,
    input  logic              bus_idle,
    output logic              card_clk,
    output logic              card_edge,
    output logic [1:0]        bus_width
);

    cclk_cfg_t  cfg;
    bus_width_e width_q;
    logic       hold;

    mmc_cclk_decode #(
        .CTRL_W     (CTRL_W),
        .FC_BIT_STD (FC_BIT_STD),
        .FC_BIT_ALT (FC_BIT_ALT)
    ) u_decode (
        .clk       (clk),
        .rst       (rst),
        .ctrl_word (ctrl_word),
        .alt_law   (alt_law),
        .cfg       (cfg),
        .width_q   (width_q)
    );

    mmc_cclk_gate u_gate (
        .cfg        (cfg),
        .fifo_ready (fifo_ready),
        .bus_idle   (bus_idle),
        .hold       (hold)
    );

    mmc_cclk_core u_core (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .alt_law   (alt_law),
        .hold      (hold),
        .card_clk  (card_clk),
        .card_edge (card_edge)
    );

    assign bus_width = width_q;

    assert_reset_quiet_R11: assert property (@(posedge clk)
        rst |=> (!card_edge && bus_width == 2'd0));

endmodule

// File: tb/mmc_cclk_gen_test.sv
module mmc_cclk_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ctrl_word = '0;
    logic        alt_law = 1'b0;
    logic        fifo_ready = 1'b1;
    logic        bus_idle = 1'b0;
    logic        card_clk;
    logic        card_edge;
    logic [1:0]  bus_width;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        int    per;
        int    hi;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    mmc_cclk_gen uut (
        .clk        (clk),
        .rst        (rst),
        .ctrl_word  (ctrl_word),
        .alt_law    (alt_law),
        .fifo_ready (fifo_ready),
        .bus_idle   (bus_idle),
        .card_clk   (card_clk),
        .card_edge  (card_edge),
        .bus_width  (bus_width)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // control word builder: div[7:0] en=8 psave=9 byp=10 bus4=11 bus8=12 fc=13/14
    function automatic logic [15:0] word(input int div, input bit en, input bit ps,
                                         input bit byp, input bit b4, input bit b8,
                                         input bit f13, input bit f14);
        logic [15:0] w;
        w = '0;
        w[7:0] = div[7:0];
        w[8]  = en;
        w[9]  = ps;
        w[10] = byp;
        w[11] = b4;
        w[12] = b8;
        w[13] = f13;
        w[14] = f14;
        return w;
    endfunction

    task automatic apply(input logic [15:0] w, input bit alt);
        @(negedge clk);
        ctrl_word = w;
        alt_law   = alt;
    endtask

    task automatic stop_all();
        @(negedge clk);
        ctrl_word  = '0;
        fifo_ready = 1'b1;
        bus_idle   = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_edge();
        do @(negedge clk); while (!card_edge);
    endtask

    task automatic count_edges(input int n, output int e);
        e = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (card_edge) e++;
        end
    endtask

    // driver: queue expected period/high pair, wait until monitor consumes it
    task automatic expect_period(input int per, input int hi, input string tag);
        exp_t x;
        x.per = per;
        x.hi  = hi;
        x.tag = tag;
        exp_q.push_back(x);
        wait (exp_q.size() == 0);
    endtask

    // monitor: measures one full card-clock period per queued item
    initial begin
        forever begin
            int per;
            int hi;
            wait (exp_q.size() > 0);
            @(negedge clk);
            while (!card_edge) @(negedge clk);
            per = 0;
            hi  = 0;
            do begin
                if (card_clk) hi++;
                per++;
                @(negedge clk);
            end while (!card_edge);
            check(per == exp_q[0].per, {exp_q[0].tag, " period"}, per, exp_q[0].per);
            check(hi == exp_q[0].hi, {exp_q[0].tag, " high"}, hi, exp_q[0].hi);
            void'(exp_q.pop_front());
        end
    end

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int e;
        int n;

        // R11: reset state
        repeat (3) @(negedge clk);
        check(card_clk == 1'b0, "R11 card_clk in reset", card_clk, 0);
        check(card_edge == 1'b0, "R11 card_edge in reset", card_edge, 0);
        check(bus_width == 2'd0, "R11 bus_width in reset", bus_width, 0);
        rst = 1'b0;

        // R1: standard law
        apply(word(0, 1, 0, 0, 0, 0, 0, 0), 0);
        expect_period(2, 1, "R1 N=0");
        apply(word(3, 1, 0, 0, 0, 0, 0, 0), 0);
        expect_period(8, 4, "R1 N=3");
        expect_period(8, 4, "R1 N=3 repeat");
        apply(word(255, 1, 0, 0, 0, 0, 0, 0), 0);
        expect_period(512, 256, "R1 N=255");
        stop_all();

        // R2 / R3: alternate law
        apply(word(1, 1, 0, 0, 0, 0, 0, 0), 1);
        expect_period(3, 1, "R2 N=1");
        apply(word(4, 1, 0, 0, 0, 0, 0, 0), 1);
        expect_period(6, 3, "R2 N=4");
        apply(word(255, 1, 0, 0, 0, 0, 0, 0), 1);
        expect_period(257, 128, "R2 N=255");
        apply(word(0, 1, 0, 0, 0, 0, 0, 0), 1);
        expect_period(2, 1, "R3 N=0");
        stop_all();

        // R9: edge is one cycle wide and starts the high phase
        apply(word(2, 1, 0, 0, 0, 0, 0, 0), 0);
        wait_edge();
        check(card_clk == 1'b1, "R9 clk high at edge", card_clk, 1);
        @(negedge clk);
        check(card_edge == 1'b0, "R9 edge width", card_edge, 0);
        check(card_clk == 1'b1, "R9 high continues", card_clk, 1);
        stop_all();

        // R8: mid-period divide change applies at next boundary
        apply(word(3, 1, 0, 0, 0, 0, 0, 0), 0);
        wait_edge();
        ctrl_word = word(1, 1, 0, 0, 0, 0, 0, 0);
        n = 0;
        do begin @(negedge clk); n++; end while (!card_edge);
        check(n == 8, "R8 old period kept", n, 8);
        n = 0;
        do begin @(negedge clk); n++; end while (!card_edge);
        check(n == 4, "R8 new period used", n, 4);
        stop_all();

        // R5: enable cleared mid-period
        apply(word(3, 1, 0, 0, 0, 0, 0, 0), 0);
        wait_edge();
        ctrl_word = word(3, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        check(card_clk == 1'b0, "R5 clk low after clear", card_clk, 0);
        count_edges(10, e);
        check(e == 0, "R5 no edges while disabled", e, 0);
        stop_all();

        // R4: bypass ignores divide
        apply(word(200, 1, 0, 1, 0, 0, 0, 0), 0);
        @(negedge clk);
        count_edges(10, e);
        check(e == 10, "R4 edge every cycle", e, 10);
        @(posedge clk);
        #2;
        check(card_clk == 1'b1, "R4 follows master high", card_clk, 1);
        @(negedge clk);
        check(card_clk == 1'b0, "R4 follows master low", card_clk, 0);
        stop_all();

        // R6: flow control, standard law uses bit 13
        apply(word(1, 1, 0, 0, 0, 0, 1, 0), 0);
        wait_edge();
        fifo_ready = 1'b0;
        count_edges(20, e);
        check(e == 0, "R6 stalled no edge", e, 0);
        check(card_clk == 1'b0, "R6 stalled low", card_clk, 0);
        fifo_ready = 1'b1;
        @(negedge clk);
        check(card_edge == 1'b1, "R6 resumes next edge", card_edge, 1);
        stop_all();

        // R6: alternate law ignores bit 13
        apply(word(1, 1, 0, 0, 0, 0, 1, 0), 1);
        fifo_ready = 1'b0;
        count_edges(20, e);
        check(e >= 6, "R6 bit13 ignored in alt", e, 6);
        stop_all();

        // R6: alternate law honours bit 14
        apply(word(1, 1, 0, 0, 0, 0, 0, 1), 1);
        wait_edge();
        fifo_ready = 1'b0;
        count_edges(20, e);
        check(e == 0, "R6 bit14 stalls in alt", e, 0);
        stop_all();

        // R7: power save while idle
        apply(word(2, 1, 1, 0, 0, 0, 0, 0), 0);
        wait_edge();
        bus_idle = 1'b1;
        count_edges(20, e);
        check(e == 0, "R7 idle no edge", e, 0);
        check(card_clk == 1'b0, "R7 idle low", card_clk, 0);
        bus_idle = 1'b0;
        @(negedge clk);
        check(card_edge == 1'b1, "R7 resumes when busy", card_edge, 1);
        stop_all();

        // R10: bus width encoding and priority
        apply(word(0, 0, 0, 0, 1, 0, 0, 0), 0);
        @(negedge clk);
        check(bus_width == 2'd1, "R10 4-bit", bus_width, 1);
        apply(word(0, 0, 0, 0, 1, 1, 0, 0), 0);
        @(negedge clk);
        check(bus_width == 2'd2, "R10 8-bit wins", bus_width, 2);
        apply(word(0, 0, 0, 0, 0, 0, 0, 0), 0);
        @(negedge clk);
        check(bus_width == 2'd0, "R10 1-bit", bus_width, 0);

        finish_run();
    end

endmodule